// File: doc/BRIEF.md
# Sub-Field Dispersed PWM Generator

This block drives the single digital bit of a filtered PWM DAC. A free-running counter defines a period of 2^CNT_W clocks. A plain PWM would make one pulse per period. This one splits the period into 2^SUB_LOG equal sub-fields and places one contiguous sub-pulse at the start of each. The total high time per period still equals the duty word. The sub-pulse widths differ by at most one clock, and the sub-fields that carry the extra clock are spread across the period in bit-reversed index order. Across the middle of the duty range the output makes a fixed number of edges per period. Any rise/fall delay mismatch in a downstream isolator then shows up as a constant offset that a calibration loop can remove, and not as a nonlinearity.

The sub-pulses come from a bit permutation of the counter applied before an ordinary magnitude compare with the duty word. A second spreading mode reverses every counter bit. It gives maximum dither but the edge count is no longer fixed. A duty word is written with a load strobe and takes effect at the next period boundary. A one-clock marker flags the first clock of every output period. In a typical use the block runs from a 200 MHz clock with a 20-bit counter and four sub-fields, which gives roughly an 800 Hz sub-pulse train. The defaults here are smaller.

Top module: `sfpwm_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `pwm_o` and `period_start_o` are low after that edge. After release the counter restarts at zero, so `period_start_o` is high at the first clock after reset is released. The output stays low until a loaded duty word becomes active.
- R2: `period_start_o` is high for exactly one clock out of every 2^CNT_W, and that clock is the first clock of an output period.
- R3: In each output period the number of clocks with `pwm_o` high equals the active duty word D, where 0 ≤ D ≤ 2^CNT_W. D = 0 gives a constant low output and D = 2^CNT_W gives a constant high output.
- R4: With `mode_i` = 0 (sub-field spreading), the period is made of 2^SUB_LOG sub-fields of 2^(CNT_W-SUB_LOG) clocks, numbered j = 0, 1, ... in time order. In each sub-field the output is high for one contiguous run that starts at the first clock of that sub-field. The run length is q = D >> SUB_LOG, or q+1.
- R5: With `mode_i` = 0, sub-field j gets the extra clock exactly when the SUB_LOG-bit reversal of j is less than D mod 2^SUB_LOG. For example, with SUB_LOG = 2 and D mod 4 = 2, sub-fields 0 and 2 get it, not 0 and 1.
- R6: With `mode_i` = 0 and a steady D in the range 2^SUB_LOG ≤ D ≤ 2^CNT_W − 2^SUB_LOG, the output toggles exactly 2^(SUB_LOG+1) times per period, counting the toggle at the period's first clock. In any period in this mode it never toggles more often than that.
- R7: With `mode_i` = 1 (full reversal), the output at counter position c of a period is high exactly when the CNT_W-bit reversal of c is less than D. For D = 2^(CNT_W-1) this gives an alternating pattern that starts high.
- R8: `duty_i` is captured on any clock with `load_i` high. The captured value becomes active only from the next period boundary, so the current period is not affected. If several loads happen in one period, the last one wins.
- R9: `mode_i` is sampled only at period boundaries. A change in mid-period first affects the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | CNT_W+1 | Duty word: high clocks per period, 0 to 2^CNT_W |
| load_i | input | 1 | Capture `duty_i` this clock |
| mode_i | input | 1 | Spreading mode: 0 = sub-field, 1 = full bit reversal |
| pwm_o | output | 1 | Registered PWM output bit |
| period_start_o | output | 1 | One-clock marker on the first clock of each output period |

## Verification
The assertions assume that `duty_i` never exceeds 2^CNT_W and that `mode_i` is a clean level. The edge-budget property is only checked in windows where the full-reversal mode was not active at any point, because that mode has no edge limit. Stimulus keeps every loaded duty word inside 0..2^CNT_W. It measures only periods whose predecessor used the same settings, except for the directed tests that change the duty word or the mode on purpose in mid-period. The sweep covers both ends of the duty range, both ends of the fixed-edge range, residues that exercise the reversed extra-clock order, and the full-reversal mode.

// File: rtl/sfpwm_pkg.sv
package sfpwm_pkg;
  typedef enum logic {
    SPREAD_SUBFIELD = 1'b0,
    SPREAD_FULLREV  = 1'b1
  } spread_mode_e;
endpackage

// File: rtl/sfpwm_counter.sv
module sfpwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end

  // last count of the period: the next edge returns to zero
  assign wrap_o = &cnt_o;
endmodule

// File: rtl/sfpwm_duty_latch.sv
module sfpwm_duty_latch
  import sfpwm_pkg::*;
#(
  parameter int DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              mode_i,
  input  logic              wrap_i,
  output logic [DUTY_W-1:0] act_duty_o,
  output spread_mode_e      act_mode_o
);
  logic [DUTY_W-1:0] pend_q;
  logic [DUTY_W-1:0] pend_nxt;

  // a load in the wrap clock itself still makes the next period
  assign pend_nxt = load_i ? duty_i : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_duty_o <= '0;
      act_mode_o <= SPREAD_SUBFIELD;
    end else begin
      pend_q <= pend_nxt;
      if (wrap_i) begin
        act_duty_o <= pend_nxt;
        act_mode_o <= spread_mode_e'(mode_i);
      end
    end
  end
endmodule

// File: rtl/sfpwm_permute.sv
module sfpwm_permute
  import sfpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SUB_LOG = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  spread_mode_e     mode_i,
  output logic [CNT_W-1:0] perm_o
);
  logic [CNT_W-1:0] sub_map;
  logic [CNT_W-1:0] rev_map;

  // sub-field index (top bits) lands reversed in the low bits,
  // the rest of the counter moves up by SUB_LOG places
  for (genvar i = 0; i < CNT_W; i++) begin : g_map
    if (i < SUB_LOG) begin : g_low
      assign sub_map[i] = cnt_i[CNT_W-1-i];
    end else begin : g_high
      assign sub_map[i] = cnt_i[i-SUB_LOG];
    end
    assign rev_map[i] = cnt_i[CNT_W-1-i];
  end

  assign perm_o = (mode_i == SPREAD_FULLREV) ? rev_map : sub_map;
endmodule

// File: rtl/sfpwm_gen.sv
module sfpwm_gen
  import sfpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SUB_LOG = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CNT_W:0] duty_i,
  input  logic           load_i,
  input  logic           mode_i,
  output logic           pwm_o,
  output logic           period_start_o
);
  localparam int DUTY_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic              cnt_wrap;
  logic [DUTY_W-1:0] act_duty;
  spread_mode_e      act_mode;
  logic [CNT_W-1:0]  perm;
  logic              hi_nxt;

  sfpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (cnt_wrap)
  );

  sfpwm_duty_latch #(.DUTY_W(DUTY_W)) u_duty (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .duty_i     (duty_i),
    .mode_i     (mode_i),
    .wrap_i     (cnt_wrap),
    .act_duty_o (act_duty),
    .act_mode_o (act_mode)
  );

  sfpwm_permute #(.CNT_W(CNT_W), .SUB_LOG(SUB_LOG)) u_perm (
    .cnt_i  (cnt),
    .mode_i (act_mode),
    .perm_o (perm)
  );

  assign hi_nxt = {1'b0, perm} < act_duty;

  // both outputs registered from the same counter state, so the
  // marker lines up with the output of count zero
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o          <= 1'b0;
      period_start_o <= 1'b0;
    end else begin
      pwm_o          <= hi_nxt;
      period_start_o <= (cnt == '0);
    end
  end
endmodule

// File: rtl/sfpwm_gen_chk.sv
module sfpwm_gen_chk
  import sfpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SUB_LOG = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           pwm_o,
  input logic           pstart_o,
  input logic [CNT_W:0] act_duty,
  input logic           wrap,
  input spread_mode_e   act_mode
);
  localparam int PER    = 1 << CNT_W;
  localparam int EDGE_B = 1 << (SUB_LOG + 1);

  logic [CNT_W+1:0] gap_q;
  logic [CNT_W+1:0] ec_q;
  logic             seen_q;
  logic             pwm_d;
  logic             rev_win_q;
  logic             tog;

  assign tog = pwm_o != pwm_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      ec_q      <= '0;
      seen_q    <= 1'b0;
      pwm_d     <= 1'b0;
      rev_win_q <= 1'b0;
    end else begin
      pwm_d <= pwm_o;
      if (pstart_o) begin
        seen_q    <= 1'b1;
        gap_q     <= 1;
        ec_q      <= {{(CNT_W+1){1'b0}}, tog};
        rev_win_q <= (act_mode == SPREAD_FULLREV);
      end else begin
        gap_q     <= gap_q + 1'b1;
        ec_q      <= ec_q + {{(CNT_W+1){1'b0}}, tog};
        rev_win_q <= rev_win_q | (act_mode == SPREAD_FULLREV);
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pwm_o && !pstart_o));

  p_marker_single_r2: assert property (@(posedge clk) disable iff (rst)
    pstart_o |=> !pstart_o);

  p_period_len_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (pstart_o == (gap_q == (CNT_W+2)'(PER))));

  p_edge_budget_r6: assert property (@(posedge clk) disable iff (rst)
    (pstart_o && seen_q && !rev_win_q) |-> (ec_q <= (CNT_W+2)'(EDGE_B)));

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_duty));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_mode));
endmodule

bind sfpwm_gen sfpwm_gen_chk #(.CNT_W(CNT_W), .SUB_LOG(SUB_LOG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwm_o    (pwm_o),
  .pstart_o (period_start_o),
  .act_duty (act_duty),
  .wrap     (cnt_wrap),
  .act_mode (act_mode)
);

// File: tb/sfpwm_gen_test.sv
`timescale 1ns/1ps
module sfpwm_gen_test;
  localparam int N      = 10;
  localparam int K      = 2;
  localparam int PER    = 1 << N;
  localparam int NSUB   = 1 << K;
  localparam int SUBLEN = PER / NSUB;
  localparam int NV     = 16;

  // stimulus: duty, mode; expected: toggles per period (-1 = not checked)
  localparam int V_DUTY [NV] = '{0, 1024, 4, 1020, 513, 514, 515, 3, 2, 1023, 700, 257, 512, 300, 1, 1000};
  localparam int V_MODE [NV] = '{0, 0,    0, 0,    0,   0,   0,   0, 0, 0,    0,   0,   1,   1,   1, 0};
  localparam int V_EDGE [NV] = '{0, 0,    8, 8,    8,   8,   8,   6, 4, 2,    8,   8,   1024, -1, 2, 8};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N:0]   duty_i = '0;
  logic         load_i = 1'b0;
  logic         mode_i = 1'b0;
  logic         pwm_o;
  logic         period_start_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic smp [PER];
  logic last_pwm = 1'b0;

  always #2.5 clk = ~clk;

  sfpwm_gen #(.CNT_W(N), .SUB_LOG(K)) uut (
    .clk(clk), .rst(rst), .duty_i(duty_i), .load_i(load_i),
    .mode_i(mode_i), .pwm_o(pwm_o), .period_start_o(period_start_o)
  );

  function automatic int rev_bits(input int v, input int w);
    int r = 0;
    for (int b = 0; b < w; b++) if (v[b]) r |= 1 << (w - 1 - b);
    return r;
  endfunction

  // expected output at position c, straight from R4/R5/R7
  function automatic logic exp_bit(input int c, input int d, input int m);
    int j, l, q, r, w;
    if (m != 0) return logic'(rev_bits(c, N) < d);
    j = c / SUBLEN;
    l = c % SUBLEN;
    q = d / NSUB;
    r = d % NSUB;
    w = q + ((rev_bits(j, K) < r) ? 1 : 0);
    return logic'(l < w);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int d, input int m);
    @(negedge clk);
    duty_i = d[N:0];
    mode_i = m[0];
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // measure one period; without skip_a, wait one full period first.
  // ev1: at sample ev1_i, load ev1_d (if >= 0) and drive mode ev1_m (if >= 0)
  // ev2: at sample ev2_i, load ev2_d
  task automatic grab(input bit skip_a, input int ev1_i, input int ev1_d, input int ev1_m,
                      input int ev2_i, input int ev2_d,
                      output int hi, output int ed, output int perr);
    logic prev;
    if (!skip_a) begin
      do @(negedge clk); while (period_start_o !== 1'b1);
      do begin
        prev = pwm_o;
        @(negedge clk);
      end while (period_start_o !== 1'b1);
    end else begin
      prev = last_pwm;
    end
    hi = 0; ed = 0; perr = 0;
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      load_i = 1'b0;
      smp[i] = pwm_o;
      if (pwm_o === 1'b1) hi++;
      if (pwm_o !== prev) ed++;
      prev = pwm_o;
      if ((period_start_o === 1'b1) != (i == 0)) perr++;
      if (i == ev1_i) begin
        if (ev1_m >= 0) mode_i = ev1_m[0];
        if (ev1_d >= 0) begin duty_i = ev1_d[N:0]; load_i = 1'b1; end
      end
      if (i == ev2_i) begin duty_i = ev2_d[N:0]; load_i = 1'b1; end
    end
    last_pwm = prev;
    @(negedge clk);
    load_i = 1'b0;
    if (period_start_o !== 1'b1) perr++;
  endtask

  function automatic int pattern_err(input int d, input int m);
    int e = 0;
    for (int c = 0; c < PER; c++) if (smp[c] !== exp_bit(c, d, m)) e++;
    return e;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin : main
    int hi, ed, perr, pe;
    // R1: outputs quiet while in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(pwm_o === 1'b0 && period_start_o === 1'b0, "R1 reset outputs",
            int'({pwm_o, period_start_o}), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(period_start_o === 1'b1, "R1 restart marker", int'(period_start_o), 1);
    check(pwm_o === 1'b0, "R1 output low after reset", int'(pwm_o), 0);

    // table sweep: R3, R4, R5, R6, R7, R2
    for (int v = 0; v < NV; v++) begin
      do_load(V_DUTY[v], V_MODE[v]);
      grab(1'b0, -1, -1, -1, -1, 0, hi, ed, perr);
      check(hi == V_DUTY[v], (V_MODE[v] != 0) ? "R7 high count" : "R3 high count", hi, V_DUTY[v]);
      if (V_EDGE[v] >= 0)
        check(ed == V_EDGE[v], (V_MODE[v] != 0) ? "R7 toggles" : "R6 toggles", ed, V_EDGE[v]);
      pe = pattern_err(V_DUTY[v], V_MODE[v]);
      check(pe == 0, (V_MODE[v] != 0) ? "R7 pattern" : "R4 R5 sub-field pattern", pe, 0);
      check(perr == 0, "R2 period marker", perr, 0);
    end

    // R8: mid-period loads do not touch the current period, last wins
    do_load(200, 0);
    grab(1'b0, 300, 900, -1, 500, 640, hi, ed, perr);
    check(hi == 200, "R8 current period kept", hi, 200);
    grab(1'b1, -1, -1, -1, -1, 0, hi, ed, perr);
    check(hi == 640, "R8 last load at next period", hi, 640);
    check(ed == 8, "R6 toggles after reload", ed, 8);
    pe = pattern_err(640, 0);
    check(pe == 0, "R8 next period pattern", pe, 0);

    // R9: mode change in mid-period first shows in the next period
    do_load(512, 0);
    grab(1'b0, 300, -1, 1, -1, 0, hi, ed, perr);
    check(ed == 8, "R9 mode held in current period", ed, 8);
    pe = pattern_err(512, 0);
    check(pe == 0, "R9 current period pattern", pe, 0);
    grab(1'b1, -1, -1, -1, -1, 0, hi, ed, perr);
    check(ed == 1024, "R9 new mode at next period", ed, 1024);
    check(hi == 512, "R9 high count after mode switch", hi, 512);
    pe = pattern_err(512, 1);
    check(pe == 0, "R9 next period pattern", pe, 0);
    check(perr == 0, "R2 marker across mode switch", perr, 0);

    finish_run();
  end
endmodule